// File: doc/BRIEF.md
# Delimiter or length packet grouper

The grouper takes a stream of received data words, one per valid/ready handshake, and gathers consecutive words into packets. A packet is closed by the first of three events. The first is a word that matches a configured delimiter value; the delimiter word becomes the last word of the packet. The second is the word that brings the packet up to a configured length. The third is the buffer reaching its full depth, in which case an overflow flag marks the packet. The closed packet is then sent out as a burst of words. The first beat carries a start marker and the last beat carries an end marker. Each packet also has two timestamps: the start time of its first word and the time at which its closing word was accepted.

Either closing criterion can be switched off by writing its all-ones code. With both switched off the block does no grouping and forwards each word straight through. The state machine has three states:

- ST_COLLECT accepts words into the buffer. It goes to ST_DRAIN when a closing word is accepted, and to ST_PASS when both criteria are disabled while the buffer is empty.
- ST_DRAIN holds input ready low and sends the stored words. It returns to ST_COLLECT after the handshake of the last beat.
- ST_PASS forwards words directly. It returns to ST_COLLECT once either criterion is enabled again.

Top module: `pkt_grouper`

## Requirements
- R1: After reset, out_valid is 0. With a criterion enabled, in_ready is 1.
- R2: When the accepted word matches the delimiter, the packet closes, and the delimiter word is sent as its final beat.
- R3: When the accepted word brings the packet to cfg_len words, the packet closes. Values 0 and 1 both give single-word packets.
- R4: When both criteria are enabled, the packet closes on whichever event happens first.
- R5: An all-ones cfg_delim (DATA_W+1 bits) disables the delimiter check. An all-ones cfg_len disables the length check.
- R6: With both criteria disabled, each word passes straight through. out_valid follows in_valid, in_ready follows out_ready, and out_sop and out_eop are 0.
- R7: The delimiter comparison uses only the low cfg_bits bits of the word and of cfg_delim.
- R8: If DEPTH words are stored without a delimiter or length close, the packet closes anyway. out_ovf is then 1 on every beat of that packet, and 0 on every beat of other packets.
- R9: out_start_time equals in_time of the first word of the packet. out_end_time equals ts_now in the cycle the closing word was accepted. Both hold steady for the whole burst.
- R10: in_ready is 0 while a packet is being sent. After the last beat the buffer is empty and the next word starts a new packet.
- R11: While out_valid is 1 and out_ready is 0 in grouping mode, out_data and the markers hold steady.
- R12: out_sop is 1 only on the first beat of a packet, and out_eop is 1 only on the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_delim | input | DATA_W+1 | Delimiter value; all ones disables |
| cfg_len | input | LEN_W | Packet length in words; all ones disables |
| cfg_bits | input | BITS_W | Number of significant data bits used for the delimiter compare |
| ts_now | input | TS_W | Current time |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Input word |
| in_time | input | TS_W | Time at which the input word began |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_ovf | output | 1 | Packet was closed by buffer depth |
| out_start_time | output | TS_W | Start time of first word of packet |
| out_end_time | output | TS_W | Time closing word was accepted |

## Verification
The assertions check several properties on every cycle:

- The output holds steady under backpressure.
- Nothing is left pending after an end beat.
- The start timestamp is latched from the first word.
- The buffer write address stays below its depth.
- A start marker appears whenever a burst begins.

Only the scenarios can show the following: which word closes a packet, including delimiter, length, first-of-both, masked compare and depth overflow, and the pass-through behaviour when both criteria are off. A scoreboard compares every output beat's data, markers, overflow flag and timestamps against a model built from the requirements.

// File: rtl/pkt_grouper_pkg.sv
package pkt_grouper_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PASS    = 2'd2
    } grp_state_e;
endpackage

// File: rtl/pg_close_detect.sv
module pg_close_detect #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4,
    parameter int LEN_W  = 5,
    parameter int BITS_W = 4
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W:0]   cfg_delim,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [CNT_W-1:0]  fill,
    output logic              delim_en,
    output logic              len_en,
    output logic              delim_hit,
    output logic              len_hit,
    output logic              full_hit
);
    logic [DATA_W-1:0] mask;
    logic [LEN_W-1:0]  next_cnt;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (BITS_W'(i) < cfg_bits);
        end
    end

    assign delim_en  = ~&cfg_delim;
    assign len_en    = ~&cfg_len;
    assign next_cnt  = LEN_W'(fill) + LEN_W'(1);
    assign delim_hit = delim_en && (((word ^ cfg_delim[DATA_W-1:0]) & mask) == '0);
    assign len_hit   = len_en && (next_cnt >= cfg_len);
    assign full_hit  = (fill == CNT_W'(DEPTH - 1));
endmodule

// File: rtl/pg_buffer.sv
module pg_buffer #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr[$clog2(DEPTH)-1:0]] <= wdata;
        end
    end

    assign rdata = mem[raddr[$clog2(DEPTH)-1:0]];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (waddr < CNT_W'(DEPTH)));
endmodule

// File: rtl/pkt_grouper.sv
module pkt_grouper
    import pkt_grouper_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    parameter int TS_W   = 32,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LEN_W  = CNT_W + 1,
    localparam int BITS_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W:0]   cfg_delim,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [TS_W-1:0]   ts_now,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TS_W-1:0]   in_time,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_ovf,
    output logic [TS_W-1:0]   out_start_time,
    output logic [TS_W-1:0]   out_end_time
);
    grp_state_e state_q, state_d;

    logic [CNT_W-1:0]  wcnt_q, rcnt_q;
    logic              ovf_q;
    logic [TS_W-1:0]   t_start_q, t_end_q;
    logic              delim_en, len_en, delim_hit, len_hit, full_hit;
    logic              close_any, bypass_cfg, wr_en, last_beat;
    logic [DATA_W-1:0] rd_data;

    pg_close_detect #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
        .LEN_W(LEN_W), .BITS_W(BITS_W)
    ) u_close (
        .word(in_data), .cfg_delim(cfg_delim), .cfg_len(cfg_len),
        .cfg_bits(cfg_bits), .fill(wcnt_q), .delim_en(delim_en),
        .len_en(len_en), .delim_hit(delim_hit), .len_hit(len_hit),
        .full_hit(full_hit)
    );

    pg_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(wcnt_q),
        .wdata(in_data), .raddr(rcnt_q), .rdata(rd_data)
    );

    assign close_any  = delim_hit | len_hit | full_hit;
    assign bypass_cfg = !delim_en && !len_en;
    assign last_beat  = (rcnt_q == wcnt_q - CNT_W'(1));
    assign wr_en      = (state_q == ST_COLLECT) && in_ready && in_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                if (bypass_cfg && wcnt_q == '0) state_d = ST_PASS;
                else if (wr_en && close_any)    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (out_ready && last_beat) state_d = ST_COLLECT;
            end
            ST_PASS: begin
                if (!bypass_cfg) state_d = ST_COLLECT;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = rd_data;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_ovf   = 1'b0;
        unique case (state_q)
            ST_COLLECT: in_ready = !(bypass_cfg && wcnt_q == '0);
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_sop   = (rcnt_q == '0);
                out_eop   = last_beat;
                out_ovf   = ovf_q;
            end
            ST_PASS: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
            end
            default: ;
        endcase
    end

    assign out_start_time = t_start_q;
    assign out_end_time   = t_end_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q    <= '0;
            rcnt_q    <= '0;
            ovf_q     <= 1'b0;
            t_start_q <= '0;
            t_end_q   <= '0;
        end else begin
            if (wr_en) begin
                wcnt_q <= wcnt_q + CNT_W'(1);
                if (wcnt_q == '0) t_start_q <= in_time;
                if (close_any) begin
                    t_end_q <= ts_now;
                    ovf_q   <= full_hit && !delim_hit && !len_hit;
                    rcnt_q  <= '0;
                end
            end
            if (state_q == ST_DRAIN && out_ready) begin
                if (last_beat) begin
                    rcnt_q <= '0;
                    wcnt_q <= '0;
                end else begin
                    rcnt_q <= rcnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    // R10
    drained_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    // R9
    start_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcnt_q == '0) |=> (out_start_time == $past(in_time)));

    // R12
    sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DRAIN) |-> (out_valid && out_sop));
endmodule

// File: tb/pkt_grouper_tb.sv
module pkt_grouper_tb;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 8;
    localparam int TS_W   = 32;
    localparam int LEN_W  = $clog2(DEPTH + 1) + 1;
    localparam int BITS_W = $clog2(DATA_W + 1);

    typedef struct {
        logic [DATA_W-1:0] data;
        logic sop, eop, ovf, ts_chk;
        logic [TS_W-1:0] t0, t1;
    } item_t;

    logic clk = 0, rst_n = 0;
    logic [DATA_W:0]   cfg_delim = '1;
    logic [LEN_W-1:0]  cfg_len = '1;
    logic [BITS_W-1:0] cfg_bits = BITS_W'(8);
    logic [TS_W-1:0]   ts_now = '0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 1;
    logic [DATA_W-1:0] in_data = '0, out_data;
    logic [TS_W-1:0]   in_time = '0, out_start_time, out_end_time;
    logic out_sop, out_eop, out_ovf;

    int checks = 0, errors = 0, rdy_mode = 0;
    bit done = 0;
    string cur_tag = "R2";
    item_t exp_q[$];
    logic [DATA_W-1:0] pend[$];
    logic [TS_W-1:0] pstart;

    pkt_grouper #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TS_W(TS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_delim(cfg_delim), .cfg_len(cfg_len),
        .cfg_bits(cfg_bits), .ts_now(ts_now), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_time(in_time),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_ovf(out_ovf),
        .out_start_time(out_start_time), .out_end_time(out_end_time)
    );

    always #5 clk = ~clk;
    always @(posedge clk) ts_now <= ts_now + 1;
    always @(negedge clk) out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ts_now[1] : 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model of accepting one word, built from the requirements
    task automatic model_accept(input logic [DATA_W-1:0] d, input logic [TS_W-1:0] tw,
                                input logic [TS_W-1:0] tn);
        item_t it;
        logic [DATA_W-1:0] m;
        bit dh, lh, full;
        bit den = ~&cfg_delim, len_en = ~&cfg_len;
        if (!den && !len_en) begin
            it = '{d, 0, 0, 0, 0, 0, 0};
            exp_q.push_back(it);
            return;
        end
        if (pend.size() == 0) pstart = tw;
        pend.push_back(d);
        m = DATA_W'((1 << cfg_bits) - 1);
        dh = den && ((d & m) == (cfg_delim[DATA_W-1:0] & m));
        lh = len_en && (pend.size() >= int'(cfg_len));
        full = (pend.size() == DEPTH);
        if (dh || lh || full) begin
            foreach (pend[i]) begin
                it = '{pend[i], i == 0, i == pend.size() - 1, full && !dh && !lh, 1, pstart, tn};
                exp_q.push_back(it);
            end
            pend.delete();
        end
    endtask

    task automatic send(input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_valid = 1;
        in_data  = d;
        in_time  = ts_now - 2;
        forever begin
            #1;
            if (in_ready) begin
                model_accept(d, in_time, ts_now);
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        item_t e;
        forever begin
            @(negedge clk);
            #2;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, {cur_tag, " unexpected beat"}, out_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_data == e.data, {cur_tag, " data"}, out_data, e.data);
                    chk(out_sop == e.sop && out_eop == e.eop, {cur_tag, " R12 markers"},
                        {out_sop, out_eop}, {e.sop, e.eop});
                    chk(out_ovf == e.ovf, {cur_tag, " R8 ovf"}, out_ovf, e.ovf);
                    if (e.ts_chk) begin
                        chk(out_start_time == e.t0, {cur_tag, " R9 start"}, out_start_time, e.t0);
                        chk(out_end_time == e.t1, {cur_tag, " R9 end"}, out_end_time, e.t1);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_delim = 10'h00A;
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1, "R1 in_ready", in_ready, 1);
        rst_n = 1;

        // R2 delimiter only, R5 length disabled
        cur_tag = "R2 R5";
        send(9'h001); send(9'h002); send(9'h00A);
        wait_idle();

        // R3 length only, delimiter disabled, with stalls
        cur_tag = "R3 R5";
        cfg_delim = '1; cfg_len = 5'd3; rdy_mode = 1;
        for (int i = 0; i < 6; i++) send(DATA_W'(9'h00A + i));
        wait_idle();
        cfg_len = 5'd0;
        send(9'h033);
        wait_idle();
        rdy_mode = 0;

        // R4 first of both
        cur_tag = "R4";
        cfg_delim = 10'h00A; cfg_len = 5'd4;
        send(9'h005); send(9'h00A);
        send(9'h001); send(9'h002); send(9'h003); send(9'h004);
        wait_idle();

        // R7 masked compare
        cur_tag = "R7";
        cfg_len = '1; cfg_bits = BITS_W'(5); cfg_delim = 10'h003;
        send(9'h040); send(9'h023);
        wait_idle();
        cfg_bits = BITS_W'(8);

        // R8 depth overflow
        cur_tag = "R8";
        cfg_delim = 10'h00A;
        for (int i = 0; i < DEPTH; i++) send(DATA_W'(9'h100 + i));
        wait_idle();

        // R10 R11 blocking and holding during drain
        cur_tag = "R10";
        rdy_mode = 2;
        send(9'h011); send(9'h00A);
        @(negedge clk); #2;
        chk(in_ready == 0, "R10 in_ready in drain", in_ready, 0);
        chk(out_valid && out_sop && out_data == 9'h011, "R11 first beat held", out_data, 9'h011);
        @(negedge clk); #2;
        chk(out_valid && out_sop && out_data == 9'h011, "R11 beat stable", out_data, 9'h011);
        rdy_mode = 0;
        wait_idle();
        chk(in_ready == 1, "R10 ready after drain", in_ready, 1);

        // R6 pass-through
        cur_tag = "R6";
        cfg_delim = '1; cfg_len = '1;
        repeat (3) @(negedge clk);
        send(9'h055); send(9'h0AA);
        wait_idle();
        rdy_mode = 2;
        @(negedge clk); #2;
        chk(in_ready == 0, "R6 in_ready follows out_ready low", in_ready, 0);
        rdy_mode = 0;
        @(negedge clk); #2;
        chk(in_ready == 1, "R6 in_ready follows out_ready high", in_ready, 1);

        chk(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule